// File: doc/BRIEF.md
# Two-Stage Multiply-Accumulate Datapath with Arithmetic Modes

This block multiplies two operands and adds the product to, or subtracts it from, a single 48-bit accumulator. The operands are either full 32-bit words or the low 16-bit halves of the operand inputs. Three mode inputs choose the arithmetic:
- unsigned-select (`mode_uns`),
- fractional-select (`mode_frac`),
- round-select (`mode_rnd`).

Together they pick signed integer, unsigned integer or signed fractional arithmetic. They also pick how a fractional 32-bit product is cut to the accumulator's precision, and how the accumulator is narrowed for a store.

Work moves through two registered stages. The first edge forms the product and its overflow. The second edge adds the product to the accumulator or subtracts it. An overflow flag and an extension-overflow flag follow one edge later. A combinational store path presents the accumulator narrowed to 32 bits, or to 16 bits in one fractional mode. That store rounds according to the current mode inputs and saturates when the value does not fit or when overflow has been recorded. A synchronous clear input empties the whole datapath.

In fractional modes the accumulator holds a signed value scaled by 2^-39. Bits 47..40 form the extension, bits 39..8 are the 32-bit fraction, and bits 7..0 are guard bits.

Top module: `mac_unit`

## Requirements
- R1: After reset, `acc` is 0, `flag_v` and `flag_ev` are 0, and `store_data` is 0.
- R2: With `mode_uns`=0 and `mode_frac`=0, an operation presented with `in_valid` before clock edge k is applied at edge k+1. It sets `acc` to `acc` + a·b (`op_sub`=0) or `acc` − a·b (`op_sub`=1), using signed operands and keeping the low 48 bits. When no operation reaches the accumulate stage, `acc` does not change.
- R3: With `mode_uns`=1 and `mode_frac`=0, the operands are zero-extended before the multiply.
- R4: With `word_sel`=0, only bits 15..0 of each operand are used. They are sign-extended, or zero-extended in unsigned integer mode. In fractional mode a 16-bit product is added as a·b·2^9 (exact, no rounding).
- R5: In fractional mode with `word_sel`=1, the contribution is floor(2·a·b / 2^24) when `mode_rnd`=0. When `mode_rnd`=1 it is floor((2·a·b + 2^23) / 2^24), so ties round up.
- R6: Product overflow is either of two cases:
  - an integer 32-bit product outside the signed 48-bit range;
  - a fractional operation whose two operands are both the most negative value of the operand width.

  Accumulate overflow is a sum outside the signed 48-bit range. Either kind sets a sticky overflow state. That state appears on `flag_v` one edge after the accumulate and stays set until a clear.
- R7: One edge after each accumulate, `flag_ev` shows whether `acc` lies outside the mode's range. The ranges are signed 32-bit (signed integer), 0..2^32−1 (unsigned integer) and signed 40-bit (fractional). A later operation that brings `acc` back into range clears `flag_ev`.
- R8: In integer modes, `store_data` is `acc[31:0]` when `acc` is in range. When `acc` is out of range or overflow is recorded, it saturates:
  - signed integer: to 0x7FFFFFFF or 0x80000000, by the sign of `acc`;
  - unsigned integer: to 0xFFFFFFFF, or to 0 when `acc` is negative.
- R9: In modes 010 and 011 (uns, frac, rnd), `store_data` is floor((`acc` + k)/2^8), with k=0 in mode 010 and k=2^7 in mode 011. It saturates to 0x7FFFFFFF or 0x80000000 when that value does not fit 32 signed bits or when overflow is recorded.
- R10: In modes 110 and 111, `store_data` is floor((`acc` + 2^23)/2^24), sign-extended to 32 bits. It saturates to 0x00007FFF or 0xFFFF8000 when that value does not fit 16 signed bits or when overflow is recorded.
- R11: `clr` at an edge sets `acc`, the sticky overflow state, `flag_v` and `flag_ev` to 0, and discards every operation in flight, including one presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of accumulator, flags and pipeline |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sub | input | 1 | 1 = subtract the product, 0 = add it |
| word_sel | input | 1 | 1 = 32-bit operands, 0 = low 16-bit halves |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| mode_uns | input | 1 | Unsigned-select mode bit |
| mode_frac | input | 1 | Fractional-select mode bit |
| mode_rnd | input | 1 | Round-select mode bit |
| acc | output | 48 | Accumulator contents |
| flag_v | output | 1 | Overflow flag (sticky until clear) |
| flag_ev | output | 1 | Extension-overflow flag of the last result |
| store_data | output | 32 | Accumulator narrowed, rounded and saturated for the current mode |

## Verification
Directed cases are chosen so that each mode gives a different answer from its neighbours:
- a negative-by-positive product, and an all-ones unsigned operand, separate signed from unsigned extension;
- a low half of 0xFFFF separates half-word from full-word selection;
- products whose cut bits are exactly one half, or more than one half, separate truncation from rounding.

Overflow cases cover the most-negative square, an integer product too wide for 48 bits, and 260 near-unity fractional accumulations that wrap the 48-bit sum. A rise and fall of the extension range shows that `flag_ev` clears while `flag_v` stays. A clear issued behind an operation in flight shows that the operation is discarded. A long run of random operations then follows, with mode changes on every operation and periodic clears. Over that run a behavioural wide-integer model is compared on every clock for the accumulator, both flags and the store value.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OP_W    = 32;
  localparam int HALF_W  = 16;
  localparam int ACC_W   = 48;
  localparam int PROD_W  = 2 * (OP_W + 1);
  localparam int GUARD_W = 8;
  localparam int CUT_W   = 24;
  localparam int FRAC_TOP = ACC_W - GUARD_W - 1;

  typedef struct packed {
    logic [ACC_W-1:0] p;
    logic             pv;
  } prod_t;

  typedef struct packed {
    logic [ACC_W-1:0] acc;
    logic             av;
  } sum_t;

  // exact product, aligned to the accumulator scale of the mode
  function automatic prod_t mul_exact(logic [OP_W-1:0] a, logic [OP_W-1:0] b,
                                      logic uns, logic frac, logic rnd, logic word);
    logic signed [OP_W:0]     ea, eb;
    logic signed [PROD_W-1:0] pr, sh;
    logic                     uint;
    prod_t                    r;
    uint = uns & ~frac;
    if (word) begin
      ea = {a[OP_W-1] & ~uint, a};
      eb = {b[OP_W-1] & ~uint, b};
    end else begin
      ea = {{(OP_W-HALF_W+1){a[HALF_W-1] & ~uint}}, a[HALF_W-1:0]};
      eb = {{(OP_W-HALF_W+1){b[HALF_W-1] & ~uint}}, b[HALF_W-1:0]};
    end
    pr = ea * eb;
    sh = '0;
    if (!frac) begin
      r.p  = pr[ACC_W-1:0];
      r.pv = !((&pr[PROD_W-1:ACC_W-1]) | ~(|pr[PROD_W-1:ACC_W-1]));
    end else if (word) begin
      sh   = (pr <<< 1) + (rnd ? (PROD_W'(1) <<< (CUT_W-1)) : PROD_W'(0));
      r.p  = {{(ACC_W-(2*OP_W+1-CUT_W)){sh[2*OP_W]}}, sh[2*OP_W:CUT_W]};
      r.pv = (a == {1'b1, {(OP_W-1){1'b0}}}) && (b == {1'b1, {(OP_W-1){1'b0}}});
    end else begin
      sh   = pr <<< (1 + GUARD_W);
      r.p  = sh[ACC_W-1:0];
      r.pv = (a[HALF_W-1:0] == {1'b1, {(HALF_W-1){1'b0}}}) &&
             (b[HALF_W-1:0] == {1'b1, {(HALF_W-1){1'b0}}});
    end
    return r;
  endfunction

  function automatic sum_t acc_step(logic [ACC_W-1:0] acc, logic [ACC_W-1:0] p, logic sub);
    logic signed [ACC_W:0] s;
    sum_t                  r;
    if (sub) s = $signed({acc[ACC_W-1], acc}) - $signed({p[ACC_W-1], p});
    else     s = $signed({acc[ACC_W-1], acc}) + $signed({p[ACC_W-1], p});
    r.acc = s[ACC_W-1:0];
    r.av  = s[ACC_W] ^ s[ACC_W-1];
    return r;
  endfunction

  function automatic logic ext_out(logic [ACC_W-1:0] acc, logic uns, logic frac);
    if (frac)     return !((&acc[ACC_W-1:FRAC_TOP]) | ~(|acc[ACC_W-1:FRAC_TOP]));
    else if (uns) return |acc[ACC_W-1:OP_W];
    else          return !((&acc[ACC_W-1:OP_W-1]) | ~(|acc[ACC_W-1:OP_W-1]));
  endfunction

  function automatic logic [OP_W-1:0] store_fmt(logic [ACC_W-1:0] acc, logic sticky,
                                                logic uns, logic frac, logic rnd);
    logic [ACC_W:0]    r;
    logic              oor;
    logic [OP_W-1:0]   v, pmax, nmax;
    r = {acc[ACC_W-1], acc};
    if (!frac) begin
      v = acc[OP_W-1:0];
      if (uns) begin
        oor  = |acc[ACC_W-1:OP_W];
        pmax = '1;
        nmax = '0;
      end else begin
        oor  = !((&acc[ACC_W-1:OP_W-1]) | ~(|acc[ACC_W-1:OP_W-1]));
        pmax = {1'b0, {(OP_W-1){1'b1}}};
        nmax = {1'b1, {(OP_W-1){1'b0}}};
      end
    end else if (!uns) begin
      r    = r + (rnd ? ((ACC_W+1)'(1) << (GUARD_W-1)) : (ACC_W+1)'(0));
      oor  = !((&r[ACC_W:FRAC_TOP]) | ~(|r[ACC_W:FRAC_TOP]));
      v    = r[FRAC_TOP:GUARD_W];
      pmax = {1'b0, {(OP_W-1){1'b1}}};
      nmax = {1'b1, {(OP_W-1){1'b0}}};
    end else begin
      r    = r + ((ACC_W+1)'(1) << (CUT_W-1));
      oor  = !((&r[ACC_W:FRAC_TOP]) | ~(|r[ACC_W:FRAC_TOP]));
      v    = {{(OP_W-HALF_W){r[FRAC_TOP]}}, r[FRAC_TOP:CUT_W]};
      pmax = {{(OP_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
      nmax = {{(OP_W-HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
    end
    return (oor | sticky) ? (acc[ACC_W-1] ? nmax : pmax) : v;
  endfunction
endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
  import mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic             word_sel,
  input  logic [OP_W-1:0]  opa,
  input  logic [OP_W-1:0]  opb,
  input  logic             mode_uns,
  input  logic             mode_frac,
  input  logic             mode_rnd,
  output logic             s1_valid,
  output logic [ACC_W-1:0] s1_p,
  output logic             s1_pv,
  output logic             s1_sub,
  output logic             s1_frac,
  output logic             s1_uns
);
  prod_t prod_c;

  always_comb prod_c = mul_exact(opa, opb, mode_uns, mode_frac, mode_rnd, word_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_p     <= '0;
      s1_pv    <= 1'b0;
      s1_sub   <= 1'b0;
      s1_frac  <= 1'b0;
      s1_uns   <= 1'b0;
    end else begin
      s1_valid <= in_valid & ~flush;
      if (in_valid) begin
        s1_p    <= prod_c.p;
        s1_pv   <= prod_c.pv;
        s1_sub  <= op_sub;
        s1_frac <= mode_frac;
        s1_uns  <= mode_uns;
      end
    end
  end
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             s1_valid,
  input  logic [ACC_W-1:0] s1_p,
  input  logic             s1_pv,
  input  logic             s1_sub,
  input  logic             s1_frac,
  input  logic             s1_uns,
  output logic [ACC_W-1:0] acc_q,
  output logic             sticky_q,
  output logic             flag_v,
  output logic             flag_ev,
  output logic             acc_fire,
  output logic             ovf_event
);
  sum_t sum_c;
  logic s2_valid, s2_frac, s2_uns;

  always_comb begin
    sum_c     = acc_step(acc_q, s1_p, s1_sub);
    acc_fire  = s1_valid & ~clr;
    ovf_event = acc_fire & (s1_pv | sum_c.av);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      sticky_q <= 1'b0;
      s2_valid <= 1'b0;
      s2_frac  <= 1'b0;
      s2_uns   <= 1'b0;
      flag_v   <= 1'b0;
      flag_ev  <= 1'b0;
    end else if (clr) begin
      acc_q    <= '0;
      sticky_q <= 1'b0;
      s2_valid <= 1'b0;
      flag_v   <= 1'b0;
      flag_ev  <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        acc_q    <= sum_c.acc;
        sticky_q <= sticky_q | ovf_event;
        s2_frac  <= s1_frac;
        s2_uns   <= s1_uns;
      end
      if (s2_valid) begin
        flag_v  <= sticky_q;
        flag_ev <= ext_out(acc_q, s2_uns, s2_frac);
      end
    end
  end
endmodule

// File: rtl/mac_store_fmt.sv
module mac_store_fmt
  import mac_pkg::*;
(
  input  logic [ACC_W-1:0] acc_q,
  input  logic             sticky_q,
  input  logic             mode_uns,
  input  logic             mode_frac,
  input  logic             mode_rnd,
  output logic [OP_W-1:0]  store_data
);
  always_comb store_data = store_fmt(acc_q, sticky_q, mode_uns, mode_frac, mode_rnd);
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic             word_sel,
  input  logic [OP_W-1:0]  opa,
  input  logic [OP_W-1:0]  opb,
  input  logic             mode_uns,
  input  logic             mode_frac,
  input  logic             mode_rnd,
  output logic [ACC_W-1:0] acc,
  output logic             flag_v,
  output logic             flag_ev,
  output logic [OP_W-1:0]  store_data
);
  logic             s1_valid, s1_pv, s1_sub, s1_frac, s1_uns;
  logic [ACC_W-1:0] s1_p;
  logic             sticky_q, acc_fire, ovf_event;

  mac_mul_stage u_mul (
    .clk(clk), .rst_n(rst_n), .flush(clr), .in_valid(in_valid), .op_sub(op_sub),
    .word_sel(word_sel), .opa(opa), .opb(opb), .mode_uns(mode_uns),
    .mode_frac(mode_frac), .mode_rnd(mode_rnd), .s1_valid(s1_valid), .s1_p(s1_p),
    .s1_pv(s1_pv), .s1_sub(s1_sub), .s1_frac(s1_frac), .s1_uns(s1_uns)
  );

  mac_acc_stage u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .s1_valid(s1_valid), .s1_p(s1_p),
    .s1_pv(s1_pv), .s1_sub(s1_sub), .s1_frac(s1_frac), .s1_uns(s1_uns),
    .acc_q(acc), .sticky_q(sticky_q), .flag_v(flag_v), .flag_ev(flag_ev),
    .acc_fire(acc_fire), .ovf_event(ovf_event)
  );

  mac_store_fmt u_store (
    .acc_q(acc), .sticky_q(sticky_q), .mode_uns(mode_uns), .mode_frac(mode_frac),
    .mode_rnd(mode_rnd), .store_data(store_data)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        mode_uns,
  input logic        mode_frac,
  input logic [47:0] acc,
  input logic        flag_v,
  input logic        flag_ev,
  input logic [31:0] store_data,
  input logic        acc_fire,
  input logic        ovf_event,
  input logic        sticky_q
);
  p_clr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == 48'd0 && !flag_v && !flag_ev));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_fire && !clr) |=> $stable(acc));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> sticky_q);

  p_v_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_v && !clr) |=> flag_v);

  p_store16_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_frac && mode_uns) |-> ((&store_data[31:15]) || !(|store_data[31:15])));
endmodule

bind mac_unit mac_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .mode_uns(mode_uns), .mode_frac(mode_frac),
  .acc(acc), .flag_v(flag_v), .flag_ev(flag_ev), .store_data(store_data),
  .acc_fire(acc_fire), .ovf_event(ovf_event), .sticky_q(sticky_q)
);

// File: tb/mac_unit_tb.sv
module mac_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, in_valid = 1'b0, op_sub = 1'b0, word_sel = 1'b1;
  logic [31:0] opa = '0, opb = '0;
  logic        mode_uns = 1'b0, mode_frac = 1'b0, mode_rnd = 1'b0;
  logic [47:0] acc;
  logic        flag_v, flag_ev;
  logic [31:0] store_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .op_sub(op_sub),
    .word_sel(word_sel), .opa(opa), .opb(opb), .mode_uns(mode_uns),
    .mode_frac(mode_frac), .mode_rnd(mode_rnd), .acc(acc), .flag_v(flag_v),
    .flag_ev(flag_ev), .store_data(store_data)
  );

  localparam logic signed [127:0] ONE = 128'sd1;

  // behavioural model state
  logic signed [127:0] m_acc, m1p;
  logic m1v, m1pv, m1s, m1f, m1u, m2v, m2f, m2u, m_st, m_v, m_ev;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic signed [127:0] wrap48(logic signed [127:0] x);
    return {{80{x[47]}}, x[47:0]};
  endfunction

  function automatic logic signed [127:0] ext(logic [31:0] a, logic word, logic uint);
    if (word) return uint ? {96'd0, a} : {{96{a[31]}}, a};
    return uint ? {112'd0, a[15:0]} : {{112{a[15]}}, a[15:0]};
  endfunction

  function automatic bit outside(logic signed [127:0] v, int bits);
    return (v > (ONE <<< (bits-1)) - 1) || (v < -(ONE <<< (bits-1)));
  endfunction

  function automatic bit m_evf(logic signed [127:0] v, logic f, logic u);
    if (f) return outside(v, 40);
    if (u) return (v < 0) || (v > (ONE <<< 32) - 1);
    return outside(v, 32);
  endfunction

  function automatic logic [31:0] m_store(logic signed [127:0] v, logic st, logic u, logic f, logic r);
    logic signed [127:0] q;
    bit oor;
    logic [31:0] pm, nm;
    if (!f && u) begin q = v; oor = (v < 0) || (v > (ONE <<< 32) - 1); pm = 32'hFFFFFFFF; nm = 32'h0; end
    else if (!f) begin q = v; oor = outside(v, 32); pm = 32'h7FFFFFFF; nm = 32'h80000000; end
    else if (!u) begin q = (v + (r ? 128 : 0)) >>> 8; oor = outside(q, 32); pm = 32'h7FFFFFFF; nm = 32'h80000000; end
    else begin q = (v + (ONE <<< 23)) >>> 24; oor = outside(q, 16); pm = 32'h00007FFF; nm = 32'hFFFF8000; end
    if (oor || st) return (v < 0) ? nm : pm;
    return q[31:0];
  endfunction

  // reference model, updated at each rising edge, compared 5 ns later
  always begin
    logic signed [127:0] pr, s;
    @(posedge clk);
    if (!rst_n) begin
      m_acc = 0; m1p = 0; m1v = 0; m1pv = 0; m1s = 0; m1f = 0; m1u = 0;
      m2v = 0; m2f = 0; m2u = 0; m_st = 0; m_v = 0; m_ev = 0;
    end else if (clr) begin
      m_acc = 0; m_st = 0; m1v = 0; m2v = 0; m_v = 0; m_ev = 0;
    end else begin
      if (m2v) begin m_v = m_st; m_ev = m_evf(m_acc, m2f, m2u); end
      m2v = m1v;
      if (m1v) begin
        m2f = m1f; m2u = m1u;
        s = m1s ? m_acc - m1p : m_acc + m1p;
        m_st = m_st | m1pv | outside(s, 48);
        m_acc = wrap48(s);
      end
      m1v = in_valid;
      if (in_valid) begin
        pr = ext(opa, word_sel, mode_uns & ~mode_frac) * ext(opb, word_sel, mode_uns & ~mode_frac);
        m1s = op_sub; m1f = mode_frac; m1u = mode_uns;
        if (!mode_frac) begin
          m1pv = outside(pr, 48); m1p = wrap48(pr);
        end else if (word_sel) begin
          m1p = (pr * 2 + (mode_rnd ? (ONE <<< 23) : 0)) >>> 24;
          m1pv = (opa == 32'h80000000) && (opb == 32'h80000000);
        end else begin
          m1p = pr * 512;
          m1pv = (opa[15:0] == 16'h8000) && (opb[15:0] == 16'h8000);
        end
      end
    end
    #5;
    if (rst_n && !done) begin
      chk("R2 acc vs model", {16'd0, acc}, {16'd0, m_acc[47:0]});
      chk("R6 flag_v vs model", {63'd0, flag_v}, {63'd0, m_v});
      chk("R7 flag_ev vs model", {63'd0, flag_ev}, {63'd0, m_ev});
      chk("R8 store vs model", {32'd0, store_data},
          {32'd0, m_store(m_acc, m_st, mode_uns, mode_frac, mode_rnd)});
    end
  end

  task automatic setm(input logic u, input logic f, input logic r);
    mode_uns = u; mode_frac = f; mode_rnd = r;
  endtask

  task automatic op(input logic sub, input logic word, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_sub = sub; word_sel = word; opa = a; opb = b;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clr();
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 acc", {16'd0, acc}, 64'd0);
    chk("R1 flags", {62'd0, flag_v, flag_ev}, 64'd0);
    chk("R1 store", {32'd0, store_data}, 64'd0);

    // R2 signed integer add and subtract
    setm(0, 0, 0);
    op(0, 1, 32'd3, 32'hFFFFFFFC);
    op(1, 1, 32'd5, 32'd6);
    idle(4);
    chk("R2 signed acc", {16'd0, acc}, {16'd0, 48'hFFFF_FFFF_FFD6});
    chk("R8 signed store", {32'd0, store_data}, {32'd0, 32'hFFFFFFD6});

    // R3 unsigned integer, R7 range, R8 saturation
    do_clr(); setm(1, 0, 0);
    op(0, 1, 32'hFFFFFFFF, 32'd2);
    idle(4);
    chk("R3 unsigned acc", {16'd0, acc}, {16'd0, 48'h0001_FFFF_FFFE});
    chk("R7 unsigned ev", {63'd0, flag_ev}, 64'd1);
    chk("R8 unsigned sat", {32'd0, store_data}, {32'd0, 32'hFFFFFFFF});

    // R4 half-word operands
    do_clr(); setm(0, 0, 0);
    op(0, 0, 32'h1234FFFF, 32'hABCD0003);
    idle(4);
    chk("R4 signed half", {16'd0, acc}, {16'd0, 48'hFFFF_FFFF_FFFD});
    do_clr(); setm(1, 0, 0);
    op(0, 0, 32'h1234FFFF, 32'hABCD0003);
    idle(4);
    chk("R4 unsigned half", {16'd0, acc}, {16'd0, 48'h0000_0002_FFFD});
    do_clr(); setm(0, 1, 0);
    op(0, 0, 32'h00004000, 32'h00004000);
    idle(4);
    chk("R4 fractional half", {16'd0, acc}, {16'd0, 48'h0020_0000_0000});

    // R5 fractional cut: truncate and round
    do_clr(); setm(0, 1, 0);
    op(0, 1, 32'd1, 32'h00C00000);
    idle(4);
    chk("R5 truncate", {16'd0, acc}, 64'd1);
    do_clr(); setm(0, 1, 1);
    op(0, 1, 32'd1, 32'h00C00000);
    idle(4);
    chk("R5 round", {16'd0, acc}, 64'd2);
    do_clr(); setm(0, 1, 1);
    op(0, 1, 32'd1, 32'h00400000);
    idle(4);
    chk("R5 tie rounds up", {16'd0, acc}, 64'd1);

    // R6 most-negative square, R9 saturation
    do_clr(); setm(0, 1, 0);
    op(0, 1, 32'h80000000, 32'h80000000);
    idle(4);
    chk("R6 min square acc", {16'd0, acc}, {16'd0, 48'h0080_0000_0000});
    chk("R6 min square v", {63'd0, flag_v}, 64'd1);
    chk("R9 store sat", {32'd0, store_data}, {32'd0, 32'h7FFFFFFF});

    // R7 extension range entered and left
    do_clr(); setm(0, 1, 0);
    op(0, 1, 32'h7FFFFFFF, 32'h7FFFFFFF);
    op(0, 1, 32'h7FFFFFFF, 32'h7FFFFFFF);
    idle(4);
    chk("R7 ev set", {62'd0, flag_v, flag_ev}, 64'd1);
    op(1, 1, 32'h7FFFFFFF, 32'h7FFFFFFF);
    op(1, 1, 32'h7FFFFFFF, 32'h7FFFFFFF);
    idle(4);
    chk("R7 ev cleared", {15'd0, acc, flag_ev}, 64'd0);

    // R6 integer product too wide
    do_clr(); setm(0, 0, 0);
    op(0, 1, 32'h7FFFFFFF, 32'h7FFFFFFF);
    idle(4);
    chk("R6 wide product v", {63'd0, flag_v}, 64'd1);

    // R6 accumulate overflow of 48 bits
    do_clr(); setm(0, 1, 0);
    for (int i = 0; i < 260; i++) op(0, 1, 32'h7FFFFFFF, 32'h7FFFFFFF);
    idle(4);
    chk("R6 accumulate overflow v", {63'd0, flag_v}, 64'd1);

    // R9 store rounding to 32
    do_clr(); setm(0, 1, 0);
    op(0, 1, 32'd3, 32'h40000000);
    idle(4);
    chk("R9 store no round", {32'd0, store_data}, 64'd1);
    setm(0, 1, 1);
    @(negedge clk);
    chk("R9 store round", {32'd0, store_data}, 64'd2);
    setm(1, 1, 0);
    @(negedge clk);
    chk("R10 store small", {32'd0, store_data}, 64'd0);

    // R10 store round to 16
    do_clr(); setm(1, 1, 0);
    op(0, 1, 32'h40000000, 32'h40000000);
    idle(4);
    chk("R10 store quarter", {32'd0, store_data}, {32'd0, 32'h00002000});
    do_clr(); setm(1, 1, 1);
    op(0, 1, 32'h7FFFFFFF, 32'h7FFFFFFF);
    idle(4);
    chk("R10 store sat", {32'd0, store_data}, {32'd0, 32'h00007FFF});

    // R11 clear discards an operation in flight
    do_clr(); setm(0, 0, 0);
    op(0, 1, 32'd100, 32'd7);
    do_clr();
    idle(4);
    chk("R11 in-flight discarded", {15'd0, acc, flag_v}, 64'd0);
    @(negedge clk);
    in_valid = 1'b1; opa = 32'd9; opb = 32'd9; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    idle(4);
    chk("R11 same-cycle discarded", {16'd0, acc}, 64'd0);

    // random operations, mode changes, periodic clears
    for (int i = 0; i < 480; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (($urandom % 8) == 0) a = 32'h80000000;
      if (($urandom % 8) == 0) b = 32'h80000000;
      setm($urandom % 2, $urandom % 2, $urandom % 2);
      if (($urandom % 5) == 0) idle(1 + $urandom % 3);
      else op($urandom % 2, $urandom % 2, a, b);
      if ((i % 60) == 59) do_clr();
    end
    idle(4);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule